// File: doc/BRIEF.md
# Counter-Addressed Twiddle Rotator Bank

This block sits between a parallel radix-8 butterfly and the next shuffling stage of a multi-path feedforward FFT pipeline. Each clock it accepts eight complex samples in parallel. It multiplies seven of the lanes by twiddle factors and passes the eighth lane, whose twiddle is always one, through unchanged. Each rotated lane reads its coefficients from its own small ROM. The ROM contents are computed at elaboration from the twiddle formula, so no table is written out by hand.

The ROM addresses come straight from the low bits of a six-bit beat counter, so there is no address generator. The counter advances once per valid input beat and holds while the input is idle. The `STAGE` parameter picks between two configurations:

- The first-stage configuration rotates by powers of the 512th root of unity and uses 64-entry ROMs.
- The second-stage configuration rotates by powers of the 64th root of unity and uses 8-entry ROMs.

All eight lanes come out together after a fixed three-cycle latency. A valid flag travels with the data through the same pipeline.

Top module: `twiddle_rotator_bank`

## Requirements
- R1: Lane 0 is not rotated: its output equals its input exactly, three cycles later.
- R2: With STAGE = first, lane k (1..7) at beat count t is multiplied by exp(-j*2*pi*k*t/512), for t = 0..63.
- R3: With STAGE = second, lane k (1..7) at beat count t is multiplied by exp(-j*2*pi*k*(t mod 8)/64).
- R4: The beat count is 0 after reset. It rises by one on each cycle with in_valid high, holds while in_valid is low, and wraps from 63 to 0.
- R5: out_valid repeats in_valid exactly three cycles later, including gaps, and every output beat carries the result of one input beat.
- R6: Coefficients are signed, COEF_W bits wide, with one integer bit, so unity is 2^(COEF_W-2). Each product is rounded to nearest: half an LSB is added, then the value is shifted right arithmetically and truncated to DATA_W bits. A unity twiddle reproduces its input exactly. For any other twiddle the result is within 2 LSB of the ideal product, for input components of magnitude below 2^(DATA_W-2).
- R7: While rst is high, and after it until the first valid beat has crossed the pipeline, out_valid is 0.
- R8: Lane k occupies bits [k*2*DATA_W +: 2*DATA_W] of in_data and out_data. The real part is in the low DATA_W bits and the imaginary part in the high DATA_W bits, each in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid; advances the beat count |
| in_data | input | LANES*2*DATA_W | Eight complex input samples, packed as in R8 |
| out_valid | output | 1 | Output beat valid, three cycles after in_valid |
| out_data | output | LANES*2*DATA_W | Eight complex output samples, packed as in R8 |

## Verification
The embedded assertions check on every cycle the properties that need no arithmetic:

- the counter steps or holds as in_valid dictates;
- out_valid follows in_valid by three cycles;
- lane 0 reappears unchanged;
- a unity coefficient leaves a multiplier's input intact;
- every ROM yields unity at address zero.

The twiddle values themselves can only be shown by the scoreboard scenarios. The bench compares each lane against an ideal floating-point rotation for every count value, with continuous and gapped input, a count wrap, and a reset in mid-run, in both stage configurations.

// File: rtl/twb_pkg.sv
package twb_pkg;

  typedef enum logic [0:0] {
    STAGE_FIRST  = 1'b0,
    STAGE_SECOND = 1'b1
  } twb_stage_e;

  localparam real TWB_PI = 3.14159265358979323846;

  // Round a real to the nearest integer after scaling by 2^frac
  function automatic int twb_quant(real v, int frac);
    real s;
    s = v * (2.0 ** frac);
    if (s >= 0.0) return $rtoi(s + 0.5);
    else          return $rtoi(s - 0.5);
  endfunction

endpackage

// File: rtl/twb_frame_counter.sv
module twb_frame_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (step) count <= count + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> (count == $past(count) + 1'b1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count)); // R4

endmodule

// File: rtl/twb_coef_rom.sv
module twb_coef_rom #(
  parameter int COEF_W   = 16,
  parameter int DEPTH    = 64,
  parameter int N_POINTS = 512,
  parameter int LANE     = 1,
  localparam int AW      = $clog2(DEPTH),
  localparam int FRAC    = COEF_W - 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            addr,
  output logic signed [COEF_W-1:0] w_re,
  output logic signed [COEF_W-1:0] w_im
);
  import twb_pkg::*;

  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) <<< FRAC;

  // W_N^(LANE*idx) = cos(a) - j*sin(a), with a = 2*pi*LANE*idx/N
  function automatic logic [2*COEF_W-1:0] make_entry(int idx);
    real ang;
    int  c_re;
    int  c_im;
    ang  = 2.0 * TWB_PI * real'(LANE * idx) / real'(N_POINTS);
    c_re = twb_quant($cos(ang), FRAC);
    c_im = twb_quant(-$sin(ang), FRAC);
    return {c_im[COEF_W-1:0], c_re[COEF_W-1:0]};
  endfunction

  logic [2*COEF_W-1:0] rom_tbl [DEPTH];
  logic [2*COEF_W-1:0] coef_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [2*COEF_W-1:0] ENTRY = make_entry(i);
    assign rom_tbl[i] = ENTRY;
  end

  // Registered read so the table maps onto a ROM primitive
  always_ff @(posedge clk) begin
    coef_q <= rom_tbl[addr];
  end

  assign w_re = coef_q[COEF_W-1:0];
  assign w_im = coef_q[2*COEF_W-1:COEF_W];

  AST_ROM_ORIGIN_UNITY: assert property (@(posedge clk) disable iff (rst)
    (addr == '0) |=> (w_re == UNITY && w_im == '0)); // R2

endmodule

// File: rtl/twb_cmult.sv
module twb_cmult #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int PW    = DATA_W + COEF_W,
  localparam int SW    = PW + 1,
  localparam int FRAC  = COEF_W - 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [DATA_W-1:0] x_re,
  input  logic signed [DATA_W-1:0] x_im,
  input  logic signed [COEF_W-1:0] w_re,
  input  logic signed [COEF_W-1:0] w_im,
  output logic signed [DATA_W-1:0] y_re,
  output logic signed [DATA_W-1:0] y_im
);

  localparam logic signed [SW-1:0]     RND   = SW'(1) <<< (FRAC - 1);
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1) <<< FRAC;

  logic signed [PW-1:0] p_rr, p_ii, p_ri, p_ir;
  logic signed [SW-1:0] s_rr, s_ii, s_ri, s_ir;

  // Stage A: four partial products
  always_ff @(posedge clk) begin
    p_rr <= x_re * w_re;
    p_ii <= x_im * w_im;
    p_ri <= x_re * w_im;
    p_ir <= x_im * w_re;
  end

  assign s_rr = SW'(p_rr);
  assign s_ii = SW'(p_ii);
  assign s_ri = SW'(p_ri);
  assign s_ir = SW'(p_ir);

  // Stage B: combine, round to nearest, drop fraction, wrap to DATA_W
  always_ff @(posedge clk) begin
    y_re <= DATA_W'((s_rr - s_ii + RND) >>> FRAC);
    y_im <= DATA_W'((s_ri + s_ir + RND) >>> FRAC);
  end

  AST_UNITY_EXACT: assert property (@(posedge clk) disable iff (rst)
    (w_re == UNITY && w_im == '0) |-> ##2
      (y_re == $past(x_re, 2) && y_im == $past(x_im, 2))); // R6

endmodule

// File: rtl/twb_lane_delay.sv
module twb_lane_delay #(
  parameter int W     = 32,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk) begin
    pipe[0] <= d;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_tap
    always_ff @(posedge clk) begin
      pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[DEPTH-1];

endmodule

// File: rtl/twiddle_rotator_bank.sv
module twiddle_rotator_bank #(
  parameter int                  FFT_N  = 512,
  parameter int                  LANES  = 8,
  parameter int                  DATA_W = 16,
  parameter int                  COEF_W = 16,
  parameter twb_pkg::twb_stage_e STAGE  = twb_pkg::STAGE_FIRST,
  localparam int                 VW     = LANES * 2 * DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [VW-1:0] in_data,
  output logic          out_valid,
  output logic [VW-1:0] out_data
);
  import twb_pkg::*;

  localparam int STAGE_N   = (STAGE == STAGE_FIRST) ? FFT_N : FFT_N / LANES;
  localparam int ROM_DEPTH = STAGE_N / LANES;
  localparam int AW        = $clog2(ROM_DEPTH);
  localparam int CNT_W     = $clog2(FFT_N / LANES);
  localparam int LAT       = 3;   // x_q + product + round stages
  localparam int LW        = 2 * DATA_W;

  logic [CNT_W-1:0] beat_cnt;
  logic [VW-1:0]    x_q;
  logic [LAT-1:0]   vld_pipe;

  twb_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .step  (in_valid),
    .count (beat_cnt)
  );

  // Data register aligned with the registered ROM read
  always_ff @(posedge clk) begin
    x_q <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) vld_pipe <= '0;
    else     vld_pipe <= {vld_pipe[LAT-2:0], in_valid};
  end
  assign out_valid = vld_pipe[LAT-1];

  // Lane 0: twiddle is always one, delay only
  twb_lane_delay #(.W(LW), .DEPTH(LAT)) u_lane0 (
    .clk (clk),
    .d   (in_data[0 +: LW]),
    .q   (out_data[0 +: LW])
  );

  for (genvar k = 1; k < LANES; k++) begin : g_rot
    logic signed [COEF_W-1:0] w_re, w_im;
    logic signed [DATA_W-1:0] y_re, y_im;

    twb_coef_rom #(
      .COEF_W   (COEF_W),
      .DEPTH    (ROM_DEPTH),
      .N_POINTS (STAGE_N),
      .LANE     (k)
    ) u_rom (
      .clk  (clk),
      .rst  (rst),
      .addr (beat_cnt[AW-1:0]),
      .w_re (w_re),
      .w_im (w_im)
    );

    twb_cmult #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mul (
      .clk  (clk),
      .rst  (rst),
      .x_re (x_q[k*LW +: DATA_W]),
      .x_im (x_q[k*LW + DATA_W +: DATA_W]),
      .w_re (w_re),
      .w_im (w_im),
      .y_re (y_re),
      .y_im (y_im)
    );

    assign out_data[k*LW +: LW] = {y_im, y_re};
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid); // R5
  AST_GAP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##3 !out_valid); // R5
  AST_LANE0_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 (out_data[0 +: LW] == $past(in_data[0 +: LW], 3))); // R1
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid); // R7

endmodule

// File: tb/twiddle_rotator_bank_tb.sv
module twiddle_rotator_bank_tb;
  import twb_pkg::*;

  localparam int DW = 16;
  localparam int LN = 8;
  localparam int VW = LN * 2 * DW;

  typedef struct packed {
    logic [5:0]    t;
    logic [VW-1:0] x;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [VW-1:0] in_data = '0;
  logic          v_a, v_b;
  logic [VW-1:0] o_a, o_b;

  item_t q_a[$];
  item_t q_b[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    beat = 0;
  bit    done = 0;

  always #10 clk = ~clk;  // 50 MHz

  twiddle_rotator_bank #(.STAGE(STAGE_FIRST)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_a), .out_data(o_a));

  twiddle_rotator_bank #(.STAGE(STAGE_SECOND)) u_dut_s2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(v_b), .out_data(o_b));

  function automatic int fld(logic [VW-1:0] v, int k, int im);
    return int'($signed(v[k*2*DW + im*DW +: DW]));
  endfunction

  function automatic int rnd(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
  endfunction

  task automatic chk(string req, string what, int act, int exp, int tol);
    int d;
    n_chk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R8 packing: lane k real at k*32, imaginary at k*32+16
  task automatic compare(int stage, item_t it, logic [VW-1:0] o);
    for (int k = 0; k < LN; k++) begin
      int    xr, xi, n, e, er, ei, tol;
      real   a;
      string req;
      xr = fld(it.x, k, 0);
      xi = fld(it.x, k, 1);
      if (k == 0) begin
        chk("R1", "lane0 re", fld(o, 0, 0), xr, 0);
        chk("R1", "lane0 im", fld(o, 0, 1), xi, 0);
      end else begin
        n = (stage == 0) ? 512 : 64;
        e = (stage == 0) ? k * int'(it.t) : k * (int'(it.t) % 8);
        a = 2.0 * TWB_PI * real'(e) / real'(n);
        er = rnd(real'(xr) * $cos(a) + real'(xi) * $sin(a));
        ei = rnd(real'(xi) * $cos(a) - real'(xr) * $sin(a));
        tol = (e == 0) ? 0 : 2;
        if (it.t == 0)     req = "R4";
        else if (e == 0)   req = "R6";
        else if (stage == 0) req = "R2";
        else               req = "R3";
        chk(req, $sformatf("s%0d lane%0d t%0d re", stage, k, it.t), fld(o, k, 0), er, tol);
        chk(req, $sformatf("s%0d lane%0d t%0d im", stage, k, it.t), fld(o, k, 1), ei, tol);
      end
    end
  endtask

  // Monitor: pop and compare as results emerge
  always @(negedge clk) begin
    if (!rst) begin
      if (v_a) begin
        if (q_a.size() == 0) chk("R5", "stage1 unexpected out_valid", 1, 0, 0);
        else compare(0, q_a.pop_front(), o_a);
      end
      if (v_b) begin
        if (q_b.size() == 0) chk("R5", "stage2 unexpected out_valid", 1, 0, 0);
        else compare(1, q_b.pop_front(), o_b);
      end
    end
  end

  // Driver: one cycle per call, pushes expected items for valid beats
  task automatic drive(bit v, logic [VW-1:0] x);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_data  = x;
    if (v) begin
      it.t = 6'(beat);
      it.x = x;
      q_a.push_back(it);
      q_b.push_back(it);
      beat++;
    end
  endtask

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] v;
    for (int j = 0; j < 2 * LN; j++)
      v[j*DW +: DW] = DW'(int'($urandom_range(0, 16382)) - 8191);
    return v;
  endfunction

  function automatic logic [VW-1:0] fill_vec(int re, int im);
    logic [VW-1:0] v;
    for (int k = 0; k < LN; k++) begin
      v[k*2*DW +: DW]      = DW'(re + 97 * k);
      v[k*2*DW + DW +: DW] = DW'(im - 53 * k);
    end
    return v;
  endfunction

  task automatic drain();
    repeat (6) drive(1'b0, '0);
    chk("R5", "stage1 pending items", q_a.size(), 0, 0);
    chk("R5", "stage2 pending items", q_b.size(), 0, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R7", "out_valid during reset s1", int'(v_a), 0, 0);
    chk("R7", "out_valid during reset s2", int'(v_b), 0, 0);
    rst = 1'b0;
    repeat (3) drive(1'b0, '0);
    chk("R7", "out_valid idle after reset", int'(v_a | v_b), 0, 0);

    // t=0 with large values: unity must be exact (R6, R4)
    drive(1'b1, fill_vec(16000, -16000));
    // Continuous random flow across the 63->0 wrap (R2, R3, R4)
    for (int i = 0; i < 70; i++) drive(1'b1, rand_vec());
    // Gapped flow: count must hold in gaps (R4, R5)
    for (int i = 0; i < 90; i++) drive(1'($urandom_range(0, 1)), rand_vec());
    // Real-only and imaginary-only patterns
    for (int i = 0; i < 12; i++) drive(1'b1, fill_vec(12000, 0));
    for (int i = 0; i < 12; i++) drive(1'b1, fill_vec(0, -12000));
    drain();

    // Reset mid-run: count restarts at 0 (R4, R7)
    for (int i = 0; i < 5; i++) drive(1'b1, rand_vec());
    drain();
    @(negedge clk);
    rst = 1'b1;
    beat = 0;
    repeat (2) @(negedge clk);
    chk("R7", "out_valid in second reset", int'(v_a | v_b), 0, 0);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) drive(1'b1, rand_vec());
    drain();

    done = 1;
    finish_run();
  end

endmodule